// File: doc/BRIEF.md
# Interrupt End-of-Service and Priority Rotation Core

This block is the service-tracking heart of an eight-level legacy interrupt controller. It latches request pulses into a pending register, picks the pending level of highest priority, and raises an interrupt line with that level number. An acknowledge moves the winning request into the in-service register. Software then retires it with an 8-bit command word that can end service for a named level or for the most urgent level, and that can move the priority ring.

Priority is circular. A lowest-priority pointer names the level that ranks last, and the level after it, modulo 8, ranks first. The rank of level `l` is `(l - lowest_level - 1) mod 8`, and rank 0 is the most urgent. A mode strap selects automatic end-of-service at acknowledge. A latched flag can then make each acknowledged level rank last. A separate configuration write records that a slave controller hangs on level 2.

The interrupt line and acknowledge are plain control pins, not a data stream. `ack` is honoured only in a cycle where `int_out` is high, and it is dropped otherwise. No back-pressure exists. A command write always takes effect at the next clock edge.

Top module: `pic_eoi_core`

## Requirements
- R1: After reset, `isr_q` and `irr_q` are 0, `lowest_level` is 7 (so level 0 ranks first), `rot_aeoi_on` and `slave_on_l2` are 0, and `int_out` is 0.
- R2: A write with `wr_sel`=0 is a command only when `wr_data[4:3]` is 00. Any other value leaves the in-service register, the pointer and the rotate flag unchanged. In a command, `wr_data[7:5]` is the operation code and `wr_data[2:0]` is the level L.
- R3: A pulse on `irq_in[l]` sets pending bit l. `int_out` is 1 exactly when some pending level ranks strictly above every in-service level. `int_level` is then the pending level of best rank.
- R4: `ack` while `int_out`=1 clears that pending bit and, with `auto_eoi_mode`=0, sets the matching in-service bit. `ack` while `int_out`=0 changes nothing.
- R5: Code 001 clears the in-service bit of best rank, and does nothing when no bit is set. Code 010 does nothing.
- R6: Code 011 clears in-service bit L.
- R7: Code 101 clears the in-service bit of best rank and makes that level the lowest. With no bit set it changes nothing.
- R8: Code 111 clears in-service bit L and sets `lowest_level` to L.
- R9: Code 110 sets `lowest_level` to L and leaves the in-service register alone.
- R10: Code 100 sets `rot_aeoi_on` and code 000 clears it. L is ignored by these codes and by codes 001 and 101.
- R11: With `auto_eoi_mode`=1, an honoured `ack` sets no in-service bit. If `rot_aeoi_on` is also 1, the acknowledged level becomes `lowest_level`.
- R12: A write with `wr_sel`=1 is a configuration word. If every bit except bit 2 is 0, `slave_on_l2` takes bit 2. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request pulses, one per level |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = command word, 1 = configuration word |
| wr_data | input | 8 | Written word |
| ack | input | 1 | Interrupt acknowledge |
| auto_eoi_mode | input | 1 | Automatic end-of-service strap |
| int_out | output | 1 | Interrupt line |
| int_level | output | 3 | Level being signalled |
| isr_q | output | 8 | In-service register |
| irr_q | output | 8 | Pending request register |
| lowest_level | output | 3 | Lowest-priority pointer |
| rot_aeoi_on | output | 1 | Rotate-on-automatic-end flag |
| slave_on_l2 | output | 1 | Cascade flag for level 2 |

## Verification
All state sits one register from the inputs, and `int_out` and `int_level` are combinational from that state. Every write, request pulse and acknowledge therefore shows its result one clock edge after it is presented. The bench drives inputs on falling edges, holds them across one rising edge, and checks on the next falling edge. A sweep covers all eight pointer positions and all 255 request patterns. It drains each pattern by acknowledging in automatic mode and compares every signalled level with a rank computed in the bench.

// File: rtl/pic_eoi_pkg.sv
package pic_eoi_pkg;
  localparam int LEVELS = 8;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    OP_ROT_AEOI_CLR = 3'b000,
    OP_NS_EOI       = 3'b001,
    OP_NOP          = 3'b010,
    OP_SP_EOI       = 3'b011,
    OP_ROT_AEOI_SET = 3'b100,
    OP_ROT_NS_EOI   = 3'b101,
    OP_SET_PRIO     = 3'b110,
    OP_ROT_SP_EOI   = 3'b111
  } op_e;

  typedef struct packed {
    logic             clr_top;
    logic             clr_lvl;
    logic             ptr_to_top;
    logic             ptr_to_lvl;
    logic             aeoi_set;
    logic             aeoi_clr;
    logic [LVL_W-1:0] lvl;
  } action_t;

  function automatic logic [LEVELS-1:0] lvl_mask(input logic [LVL_W-1:0] l);
    return {{(LEVELS-1){1'b0}}, 1'b1} << l;
  endfunction
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_eoi_pkg::*;
(
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output action_t           act,
  output logic              cfg_wr,
  output logic              cfg_val
);
  logic cmd_hit;
  op_e  op;

  assign cmd_hit = wr_en && !wr_sel && (wr_data[4:3] == 2'b00);
  assign op      = op_e'(wr_data[7:5]);

  always_comb begin
    act     = '0;
    act.lvl = wr_data[LVL_W-1:0];
    if (cmd_hit) begin
      unique case (op)
        OP_ROT_AEOI_CLR: act.aeoi_clr = 1'b1;
        OP_NS_EOI:       act.clr_top  = 1'b1;
        OP_NOP:          ;
        OP_SP_EOI:       act.clr_lvl  = 1'b1;
        OP_ROT_AEOI_SET: act.aeoi_set = 1'b1;
        OP_ROT_NS_EOI: begin
          act.clr_top    = 1'b1;
          act.ptr_to_top = 1'b1;
        end
        OP_SET_PRIO:     act.ptr_to_lvl = 1'b1;
        OP_ROT_SP_EOI: begin
          act.clr_lvl    = 1'b1;
          act.ptr_to_lvl = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cfg_wr  = wr_en && wr_sel && (wr_data[7:3] == 5'b0) && (wr_data[1:0] == 2'b0);
  assign cfg_val = wr_data[2];
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low_ptr,
  output logic          found,
  output logic [LW-1:0] level,
  output logic [LW-1:0] rank
);
  always_comb begin
    logic [LW-1:0] idx;
    found = 1'b0;
    level = '0;
    rank  = '0;
    for (int r = N - 1; r >= 0; r--) begin
      idx = low_ptr + LW'(r + 1);
      if (vec[idx]) begin
        found = 1'b1;
        level = idx;
        rank  = LW'(r);
      end
    end
  end
endmodule

// File: rtl/pic_eoi_core.sv
module pic_eoi_core
  import pic_eoi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ack,
  input  logic              auto_eoi_mode,
  output logic              int_out,
  output logic [LVL_W-1:0]  int_level,
  output logic [LEVELS-1:0] isr_q,
  output logic [LEVELS-1:0] irr_q,
  output logic [LVL_W-1:0]  lowest_level,
  output logic              rot_aeoi_on,
  output logic              slave_on_l2
);
  action_t act;
  logic    cfg_wr, cfg_val;

  logic             req_found, isr_found;
  logic [LVL_W-1:0] req_lvl, req_rank, isr_lvl, isr_rank;

  logic              grant;
  logic [LEVELS-1:0] grant_mask, clr_mask;
  logic [LEVELS-1:0] isr_d, irr_d;
  logic [LVL_W-1:0]  ptr_d;
  logic              rot_d;

  pic_cmd_decode u_dec (
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .act     (act),
    .cfg_wr  (cfg_wr),
    .cfg_val (cfg_val)
  );

  pic_prio_pick #(.N(LEVELS)) u_req_pick (
    .vec     (irr_q),
    .low_ptr (lowest_level),
    .found   (req_found),
    .level   (req_lvl),
    .rank    (req_rank)
  );

  pic_prio_pick #(.N(LEVELS)) u_isr_pick (
    .vec     (isr_q),
    .low_ptr (lowest_level),
    .found   (isr_found),
    .level   (isr_lvl),
    .rank    (isr_rank)
  );

  assign int_out   = req_found && (!isr_found || (req_rank < isr_rank));
  assign int_level = req_lvl;
  assign grant     = ack && int_out;

  assign grant_mask = grant ? lvl_mask(req_lvl) : '0;

  always_comb begin
    clr_mask = '0;
    if (act.clr_top && isr_found) clr_mask = lvl_mask(isr_lvl);
    if (act.clr_lvl)              clr_mask = lvl_mask(act.lvl);
  end

  always_comb begin
    isr_d = isr_q;
    if (!auto_eoi_mode) isr_d = isr_d | grant_mask;
    isr_d = isr_d & ~clr_mask;
    irr_d = (irr_q & ~grant_mask) | irq_in;
  end

  always_comb begin
    ptr_d = lowest_level;
    if (grant && auto_eoi_mode && rot_aeoi_on) ptr_d = req_lvl;
    if (act.ptr_to_top && isr_found)           ptr_d = isr_lvl;
    if (act.ptr_to_lvl)                        ptr_d = act.lvl;
  end

  always_comb begin
    rot_d = rot_aeoi_on;
    if (act.aeoi_set) rot_d = 1'b1;
    if (act.aeoi_clr) rot_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q        <= '0;
      irr_q        <= '0;
      lowest_level <= LVL_W'(LEVELS - 1);
      rot_aeoi_on  <= 1'b0;
      slave_on_l2  <= 1'b0;
    end else begin
      isr_q        <= isr_d;
      irr_q        <= irr_d;
      lowest_level <= ptr_d;
      rot_aeoi_on  <= rot_d;
      if (cfg_wr) slave_on_l2 <= cfg_val;
    end
  end
endmodule

// File: rtl/pic_eoi_core_chk.sv
module pic_eoi_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       ack,
  input logic       auto_eoi_mode,
  input logic       int_out,
  input logic [2:0] int_level,
  input logic [7:0] isr_q,
  input logic [7:0] irr_q,
  input logic [2:0] lowest_level,
  input logic       rot_aeoi_on,
  input logic       slave_on_l2
);
  logic cmd_ok;
  assign cmd_ok = wr_en && !wr_sel && (wr_data[4:3] == 2'b00);

  p_int_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> irr_q[int_level]);

  p_int_not_serviced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !isr_q[int_level]);

  p_ack_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !auto_eoi_mode && !wr_en) |=> isr_q[$past(int_level)]);

  p_ignored_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && (wr_data[4:3] != 2'b00) && !ack)
      |=> ($stable(isr_q) && $stable(lowest_level) && $stable(rot_aeoi_on)));

  p_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && wr_data[7:5] == 3'b010 && !ack)
      |=> ($stable(isr_q) && $stable(lowest_level)));

  p_spec_eoi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && wr_data[7:5] == 3'b011) |=> !isr_q[$past(wr_data[2:0])]);

  p_rot_spec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && wr_data[7:5] == 3'b111)
      |=> (!isr_q[$past(wr_data[2:0])] && lowest_level == $past(wr_data[2:0])));

  p_set_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && wr_data[7:5] == 3'b110) |=> (lowest_level == $past(wr_data[2:0])));

  p_aeoi_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && wr_data[7:5] == 3'b100) |=> rot_aeoi_on);

  p_aeoi_no_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi_mode && !wr_en) |=> $stable(isr_q));

  p_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data == 8'h04) |=> slave_on_l2);
endmodule

bind pic_eoi_core pic_eoi_core_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .wr_data       (wr_data),
  .ack           (ack),
  .auto_eoi_mode (auto_eoi_mode),
  .int_out       (int_out),
  .int_level     (int_level),
  .isr_q         (isr_q),
  .irr_q         (irr_q),
  .lowest_level  (lowest_level),
  .rot_aeoi_on   (rot_aeoi_on),
  .slave_on_l2   (slave_on_l2)
);

// File: tb/pic_eoi_core_test.sv
module pic_eoi_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       auto_eoi_mode = 1'b0;
  logic       int_out;
  logic [2:0] int_level;
  logic [7:0] isr_q, irr_q;
  logic [2:0] lowest_level;
  logic       rot_aeoi_on, slave_on_l2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pic_eoi_core uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .auto_eoi_mode(auto_eoi_mode),
    .int_out(int_out), .int_level(int_level), .isr_q(isr_q), .irr_q(irr_q),
    .lowest_level(lowest_level), .rot_aeoi_on(rot_aeoi_on), .slave_on_l2(slave_on_l2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int top_of(input int v, input int lo);
    for (int r = 0; r < 8; r++) begin
      int l;
      l = (lo + 1 + r) & 7;
      if (v[l]) return l;
    end
    return -1;
  endfunction

  task automatic write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic raise(input logic [7:0] p);
    @(negedge clk);
    irq_in = p;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(isr_q == 0, "R1 isr", isr_q, 0);
    check(irr_q == 0, "R1 irr", irr_q, 0);
    check(lowest_level == 7, "R1 lowest", lowest_level, 7);
    check(!rot_aeoi_on && !slave_on_l2, "R1 flags", rot_aeoi_on, 0);
    check(!int_out, "R1 int_out", int_out, 0);

    // R3 / R9 sweep: every pointer and request pattern, drained in auto mode
    auto_eoi_mode = 1'b1;
    for (int lo = 0; lo < 8; lo++) begin
      write(1'b0, 8'hC0 | 8'(lo));
      check(lowest_level == 3'(lo), "R9 set prio", lowest_level, lo);
      for (int p = 1; p < 256; p++) begin
        int rem;
        rem = p;
        raise(8'(p));
        check(irr_q == 8'(p), "R3 latch", irr_q, p);
        while (rem != 0) begin
          int e;
          e = top_of(rem, lo);
          check(int_out && int_level == 3'(e), "R3 level", int_level, e);
          do_ack();
          rem = rem & ~(1 << e);
        end
        check(!int_out && irr_q == 0 && isr_q == 0, "R11 drained", irr_q, 0);
      end
    end

    // Directed end-of-service sequence
    auto_eoi_mode = 1'b0;
    write(1'b0, 8'hC7);
    raise(8'h24);
    check(int_out && int_level == 2, "R3 pick 2", int_level, 2);
    do_ack();
    check(isr_q == 8'h04 && irr_q == 8'h20, "R4 ack", isr_q, 8'h04);
    check(!int_out, "R3 blocked by service", int_out, 0);
    raise(8'h02);
    check(int_out && int_level == 1, "R3 preempt", int_level, 1);
    do_ack();
    check(isr_q == 8'h06, "R4 nested", isr_q, 8'h06);
    write(1'b0, 8'h20);
    check(isr_q == 8'h04, "R5 ns eoi", isr_q, 8'h04);
    write(1'b0, 8'h40);
    check(isr_q == 8'h04 && lowest_level == 7, "R5 nop", isr_q, 8'h04);
    write(1'b0, 8'h28);
    check(isr_q == 8'h04, "R2 wrong select", isr_q, 8'h04);
    write(1'b1, 8'h20);
    check(isr_q == 8'h04 && !slave_on_l2, "R12 bad cfg", isr_q, 8'h04);
    write(1'b0, 8'h62);
    check(isr_q == 8'h00, "R6 spec eoi", isr_q, 0);
    check(int_out && int_level == 5, "R3 level 5", int_level, 5);
    do_ack();
    write(1'b0, 8'hA0);
    check(isr_q == 0 && lowest_level == 5, "R7 rot ns eoi", lowest_level, 5);
    write(1'b0, 8'hA0);
    check(lowest_level == 5, "R7 empty", lowest_level, 5);
    write(1'b0, 8'h20);
    check(isr_q == 0, "R5 empty", isr_q, 0);
    do_ack();
    check(isr_q == 0 && irr_q == 0, "R4 ack ignored", isr_q, 0);
    raise(8'h08);
    do_ack();
    check(isr_q == 8'h08, "R4 ack 3", isr_q, 8'h08);
    write(1'b0, 8'hE3);
    check(isr_q == 0 && lowest_level == 3, "R8 rot spec", lowest_level, 3);
    raise(8'h10);
    do_ack();
    write(1'b0, 8'hC6);
    check(lowest_level == 6 && isr_q == 8'h10, "R9 no eoi", isr_q, 8'h10);
    write(1'b0, 8'h64);
    check(isr_q == 0, "R6 clear 4", isr_q, 0);

    // R10 flag control, level bits ignored
    write(1'b0, 8'h87);
    check(rot_aeoi_on && lowest_level == 6, "R10 set", lowest_level, 6);
    write(1'b0, 8'h07);
    check(!rot_aeoi_on, "R10 clear", rot_aeoi_on, 0);

    // R11 rotation at acknowledge
    auto_eoi_mode = 1'b1;
    write(1'b0, 8'h80);
    raise(8'h81);
    check(int_level == 7, "R11 pick 7", int_level, 7);
    do_ack();
    check(isr_q == 0 && lowest_level == 7, "R11 rotate 7", lowest_level, 7);
    check(int_level == 0, "R11 pick 0", int_level, 0);
    do_ack();
    check(lowest_level == 0, "R11 rotate 0", lowest_level, 0);
    write(1'b0, 8'h00);
    raise(8'h04);
    do_ack();
    check(lowest_level == 0 && isr_q == 0, "R11 no rotate", lowest_level, 0);

    // R12 configuration word
    write(1'b1, 8'h04);
    check(slave_on_l2, "R12 set", slave_on_l2, 1);
    write(1'b1, 8'h05);
    check(slave_on_l2, "R12 ignored", slave_on_l2, 1);
    write(1'b1, 8'h00);
    check(!slave_on_l2, "R12 clear", slave_on_l2, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule